// File: doc/BRIEF.md
# Configurable-Associativity Cache Lookup

This block is the tag-compare and way-steering stage of a small cache built from four physical banks. Each bank stores a tag, a valid bit and a 256-bit line for each of 64 sets. A run-time mode input sets how the banks are grouped: as a four-way set-associative cache, as a two-way cache made of two bank pairs, or as a direct-mapped cache of four banks side by side. In the narrower modes, address bits 12 and 11 choose which banks are probed. Only those banks can hit or receive a refill. The physical arrays stay the same in every mode.

A per-bank enable mask removes banks from service, which shrinks the usable capacity. Lookups are single-cycle requests, and hit, hit-way and the addressed 32-bit word come back on the next cycle. Lines arrive through a whole-line refill port. The refill writes the line in place if that line is already present in its group. Otherwise a round-robin pointer picks the victim. Any change to the mode or to the enable mask empties the cache.

Top module: `cfgc_lookup`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_hit` are 0, and every lookup misses until a line is refilled.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req` high. `rsp_hit`, `rsp_way` and `rsp_data` describe that request and are valid in that cycle.
- R3: An address splits as follows: bits 1..0 are the byte offset, bits 4..2 are the word index, bits 10..5 are the set index and bits 31..11 are the stored tag. On a hit, `rsp_data` is word k of the line, where word k is bits 32k+31..32k of `refill_line`.
- R4: With `cfg_mode` = 2'b00 (four-way), every enabled bank is probed, and a line refilled into any of them hits.
- R5: With `cfg_mode` = 2'b01 (two-way), address bit 11 = 0 restricts probing and refill to banks 0 and 1, and bit 11 = 1 restricts them to banks 2 and 3.
- R6: With `cfg_mode` = 2'b10 or 2'b11 (direct-mapped), address bits 12..11 name the only bank that is probed or refilled.
- R7: Bit w of `way_en` enables bank w. A disabled bank never hits and never takes a refill. A refill whose group holds no enabled bank is dropped.
- R8: A change of `cfg_mode` or `way_en` between two cycles invalidates every line. A lookup or refill presented in the cycle of the change misses or is dropped.
- R9: The victim is the first candidate bank found by searching upward and wrapping, starting at a round-robin pointer. The pointer resets to 0 and becomes victim+1 (mod 4) after each such refill. A flush leaves the pointer unchanged.
- R10: A refill whose tag is already valid in a candidate bank of the addressed set overwrites that bank and leaves the pointer unchanged.
- R11: `rsp_way` gives the index (0..3) of the bank that hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Bank grouping: 00 four-way, 01 two-way, 1x direct-mapped |
| way_en | input | 4 | Per-bank enable mask |
| req | input | 1 | Lookup strobe |
| req_addr | input | 32 | Lookup byte address |
| refill_we | input | 1 | Refill write strobe |
| refill_addr | input | 32 | Address of the line being refilled |
| refill_line | input | 256 | Full line data, word 0 in the low bits |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Bank index that hit |
| rsp_data | output | 32 | Addressed word of the hitting line |

## Verification
The bench fills one set past capacity to check round-robin eviction. If the pointer were wrong, the wrong line would be evicted, and a line expected to survive would miss. It refills a line that is already present and then refills a new line. A design that allocated a duplicate would move the pointer, and the following victim would be the wrong bank. In two-way and direct-mapped modes, it looks up addresses that differ only in bits 12 or 11. If those bits were left out of the stored tag, a false hit would result. It masks off banks, then issues lookups and refills in the same cycle as a configuration change. A design that missed the flush would return stale hits, and a design that ignored the mask would place lines in dead banks.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;

    localparam int ADDR_W   = 32;
    localparam int WORD_W   = 32;
    localparam int OFF_W    = 5;
    localparam int IDX_W    = 6;
    localparam int WAYS     = 4;
    localparam int WAY_W    = $clog2(WAYS);
    localparam int BYTE_W   = $clog2(WORD_W / 8);
    localparam int WSEL_W   = OFF_W - BYTE_W;
    localparam int WPL      = 1 << WSEL_W;
    localparam int LINE_W   = WPL * WORD_W;
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;

    typedef enum logic [1:0] {
        MODE_4W  = 2'b00,
        MODE_2W  = 2'b01,
        MODE_DM  = 2'b10,
        MODE_DMX = 2'b11
    } mode_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] word;
        logic [BYTE_W-1:0] byte_off;
    } cc_addr_t;

    // Banks allowed to serve an address under a given grouping.
    function automatic logic [WAYS-1:0] group_mask(
        input mode_e m, input logic [1:0] sel, input logic [WAYS-1:0] en);
        logic [WAYS-1:0] g;
        case (m)
            MODE_4W: g = '1;
            MODE_2W: g = sel[0] ? 4'b1100 : 4'b0011;
            default: g = 4'b0001 << sel;
        endcase
        return g & en;
    endfunction

    function automatic logic [WAY_W-1:0] way_index(input logic [WAYS-1:0] oh);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int w = 0; w < WAYS; w++)
            if (oh[w]) r = WAY_W'(w);
        return r;
    endfunction

endpackage

// File: rtl/cfgc_bank.sv
module cfgc_bank #(
    parameter int IDX_BITS  = 6,
    parameter int TAG_BITS  = 21,
    parameter int LINE_BITS = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 wr_en,
    input  logic [IDX_BITS-1:0]  wr_idx,
    input  logic [TAG_BITS-1:0]  wr_tag,
    input  logic [LINE_BITS-1:0] wr_line,
    input  logic [IDX_BITS-1:0]  rd_idx,
    output logic                 rd_valid,
    output logic [TAG_BITS-1:0]  rd_tag,
    output logic [LINE_BITS-1:0] rd_line,
    input  logic [IDX_BITS-1:0]  pr_idx,
    output logic                 pr_valid,
    output logic [TAG_BITS-1:0]  pr_tag
);
    localparam int SETS = 1 << IDX_BITS;

    logic [SETS-1:0]      valid_q;
    logic [TAG_BITS-1:0]  tag_mem  [SETS];
    logic [LINE_BITS-1:0] line_mem [SETS];

    always_ff @(posedge clk) begin
        if (rst || flush)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_line  = line_mem[rd_idx];
    assign pr_valid = valid_q[pr_idx];
    assign pr_tag   = tag_mem[pr_idx];

endmodule

// File: rtl/cfgc_victim.sv
module cfgc_victim #(
    parameter int N     = 4,
    parameter int IDX_B = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     cand,
    input  logic             step,
    output logic [IDX_B-1:0] victim,
    output logic             any
);
    logic [IDX_B-1:0] ptr_q;

    always_comb begin
        victim = '0;
        any    = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(ptr_q) + k) % N;
            if (!any && cand[j]) begin
                any    = 1'b1;
                victim = IDX_B'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (step && any)
            ptr_q <= (int'(victim) == N - 1) ? '0 : victim + 1'b1;
    end

endmodule

// File: rtl/cfgc_lookup.sv
module cfgc_lookup
    import cfgc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                cfg_mode,
    input  logic [WAYS-1:0]           way_en,
    input  logic                      req,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      refill_we,
    input  logic [ADDR_W-1:0]         refill_addr,
    input  logic [LINE_W-1:0]         refill_line,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic [WAY_W-1:0]          rsp_way,
    output logic [WORD_W-1:0]         rsp_data
);
    cc_addr_t lk_a, rf_a;
    mode_e    mode;
    logic [1:0]      mode_q;
    logic [WAYS-1:0] en_q;
    logic            chg;

    logic [WAYS-1:0] lk_cand, rf_cand, lk_match, rf_match, wr_en;
    logic [WAYS-1:0] rd_valid, pr_valid;
    logic [TAG_W-1:0]  rd_tag [WAYS];
    logic [TAG_W-1:0]  pr_tag [WAYS];
    logic [LINE_W-1:0] rd_line [WAYS];
    logic [LINE_W-1:0] sel_line;
    logic [WAY_W-1:0]  victim, target;
    logic              vic_any, rf_go, vic_step;
    logic              unused_bits;

    assign lk_a = cc_addr_t'(req_addr);
    assign rf_a = cc_addr_t'(refill_addr);
    assign mode = mode_e'(cfg_mode);
    assign unused_bits = ^{lk_a.byte_off, rf_a.word, rf_a.byte_off};

    // Held copy of the configuration; any difference triggers a flush.
    always_ff @(posedge clk) begin
        mode_q <= cfg_mode;
        en_q   <= way_en;
    end
    assign chg = !rst && ((cfg_mode != mode_q) || (way_en != en_q));

    assign lk_cand = group_mask(mode, lk_a.tag[1:0], way_en);
    assign rf_cand = group_mask(mode, rf_a.tag[1:0], way_en);

    for (genvar w = 0; w < WAYS; w++) begin : g_bank
        cfgc_bank #(.IDX_BITS(IDX_W), .TAG_BITS(TAG_W), .LINE_BITS(LINE_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .flush    (chg),
            .wr_en    (wr_en[w]),
            .wr_idx   (rf_a.idx),
            .wr_tag   (rf_a.tag),
            .wr_line  (refill_line),
            .rd_idx   (lk_a.idx),
            .rd_valid (rd_valid[w]),
            .rd_tag   (rd_tag[w]),
            .rd_line  (rd_line[w]),
            .pr_idx   (rf_a.idx),
            .pr_valid (pr_valid[w]),
            .pr_tag   (pr_tag[w])
        );
        assign lk_match[w] = lk_cand[w] && rd_valid[w] && (rd_tag[w] == lk_a.tag);
        assign rf_match[w] = rf_cand[w] && pr_valid[w] && (pr_tag[w] == rf_a.tag);
        assign wr_en[w]    = rf_go && (target == WAY_W'(w));
    end

    cfgc_victim #(.N(WAYS)) u_victim (
        .clk    (clk),
        .rst    (rst),
        .cand   (rf_cand),
        .step   (vic_step),
        .victim (victim),
        .any    (vic_any)
    );

    assign rf_go    = refill_we && !chg && vic_any;
    assign vic_step = rf_go && (rf_match == '0);
    assign target   = (rf_match != '0) ? way_index(rf_match) : victim;

    always_comb begin
        sel_line = '0;
        for (int w = 0; w < WAYS; w++)
            if (lk_match[w]) sel_line = rd_line[w];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req;
            rsp_hit   <= req && !chg && (lk_match != '0);
            rsp_way   <= way_index(lk_match);
            rsp_data  <= sel_line[int'(lk_a.word) * WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/cfgc_lookup_chk.sv
module cfgc_lookup_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_mode,
    input logic [3:0] way_en,
    input logic       req,
    input logic [1:0] req_sel,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic [1:0] rsp_way
);
    logic [1:0] mode_d, sel_d;
    logic [3:0] en_d;

    always_ff @(posedge clk) begin
        mode_d <= cfg_mode;
        en_d   <= way_en;
        sel_d  <= req_sel;
    end

    a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
        req |=> rsp_valid);

    a_r2_hit_only_in_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    a_r7_no_disabled_hit: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> en_d[rsp_way]);

    a_r6_dm_bank: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && mode_d[1]) |-> (rsp_way == sel_d));

    a_r5_pair_bank: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && mode_d == 2'b01) |-> (rsp_way[1] == sel_d[0]));

    a_r8_change_misses: assert property (@(posedge clk) disable iff (rst)
        (req && (cfg_mode != mode_d || way_en != en_d)) |=> !rsp_hit);

endmodule

bind cfgc_lookup cfgc_lookup_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_mode  (cfg_mode),
    .way_en    (way_en),
    .req       (req),
    .req_sel   (req_addr[12:11]),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_way   (rsp_way)
);

// File: tb/cfgc_lookup_tb.sv
`timescale 1ns/1ps
module cfgc_lookup_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   cfg_mode;
    logic [3:0]   way_en;
    logic         req;
    logic [31:0]  req_addr;
    logic         refill_we;
    logic [31:0]  refill_addr;
    logic [255:0] refill_line;
    logic         rsp_valid, rsp_hit;
    logic [1:0]   rsp_way;
    logic [31:0]  rsp_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cfgc_lookup u_dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .way_en(way_en),
        .req(req), .req_addr(req_addr), .refill_we(refill_we),
        .refill_addr(refill_addr), .refill_line(refill_line),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_data(rsp_data)
    );

    function automatic logic [31:0] mk_addr(input logic [20:0] tag, input logic [5:0] set,
                                            input logic [2:0] word);
        return {tag, set, word, 2'b00};
    endfunction

    function automatic logic [31:0] mk_word(input logic [23:0] seed, input int k);
        return {seed, 5'b0, 3'(k)};
    endfunction

    function automatic logic [255:0] mk_line(input logic [23:0] seed);
        logic [255:0] l;
        for (int k = 0; k < 8; k++) l[k*32 +: 32] = mk_word(seed, k);
        return l;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic refill(input logic [31:0] a, input logic [23:0] seed);
        @(negedge clk);
        refill_we = 1'b1; refill_addr = a; refill_line = mk_line(seed);
        @(negedge clk);
        refill_we = 1'b0;
    endtask

    task automatic setcfg(input logic [1:0] m, input logic [3:0] e);
        @(negedge clk);
        cfg_mode = m; way_en = e;
        @(negedge clk);
    endtask

    // Lookup; expected word taken from seed and the address word index.
    task automatic look(input string tag, input logic [31:0] a, input bit eh,
                        input logic [1:0] ew, input logic [23:0] seed);
        @(negedge clk);
        req = 1'b1; req_addr = a;
        @(negedge clk);
        req = 1'b0;
        check({tag, " valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " hit"}, 64'(rsp_hit), 64'(eh));
        if (eh) begin
            check({tag, " way"}, 64'(rsp_way), 64'(ew));
            check({tag, " data"}, 64'(rsp_data), 64'(mk_word(seed, int'(a[4:2]))));
        end
    endtask

    task automatic t_reset;
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R1 rsp_hit after reset", 64'(rsp_hit), 64'd0);
        look("R1 empty lookup", mk_addr(21'h100, 6'd3, 3'd0), 1'b0, 2'd0, 24'h0);
        @(negedge clk);
        check("R2 no rsp without req", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_four_way;
        // R4 R9: set 3 filled in ways 0..3, fifth line evicts way 0
        refill(mk_addr(21'h100, 6'd3, 3'd0), 24'hA0);
        refill(mk_addr(21'h200, 6'd3, 3'd0), 24'hB0);
        refill(mk_addr(21'h300, 6'd3, 3'd0), 24'hC0);
        refill(mk_addr(21'h400, 6'd3, 3'd0), 24'hD0);
        look("R4 R11 line B way1", mk_addr(21'h200, 6'd3, 3'd2), 1'b1, 2'd1, 24'hB0);
        look("R4 R11 line D way3", mk_addr(21'h400, 6'd3, 3'd7), 1'b1, 2'd3, 24'hD0);
        refill(mk_addr(21'h500, 6'd3, 3'd0), 24'hE0);
        look("R9 line A evicted", mk_addr(21'h100, 6'd3, 3'd0), 1'b0, 2'd0, 24'h0);
        look("R9 R3 line E way0 word5", mk_addr(21'h500, 6'd3, 3'd5), 1'b1, 2'd0, 24'hE0);
        look("R3 other set misses", mk_addr(21'h500, 6'd4, 3'd0), 1'b0, 2'd0, 24'h0);
    endtask

    task automatic t_rewrite;
        // R10: B rewritten in way1, pointer stays at 1, so F replaces B
        refill(mk_addr(21'h200, 6'd3, 3'd0), 24'hB1);
        look("R10 B updated in place", mk_addr(21'h200, 6'd3, 3'd1), 1'b1, 2'd1, 24'hB1);
        refill(mk_addr(21'h600, 6'd3, 3'd0), 24'hF0);
        look("R10 F took way1", mk_addr(21'h600, 6'd3, 3'd3), 1'b1, 2'd1, 24'hF0);
        look("R10 B gone", mk_addr(21'h200, 6'd3, 3'd0), 1'b0, 2'd0, 24'h0);
        look("R10 C untouched", mk_addr(21'h300, 6'd3, 3'd0), 1'b1, 2'd2, 24'hC0);
    endtask

    task automatic t_flush;
        // R8: lookup in the cycle of the mode change misses
        @(negedge clk);
        cfg_mode = 2'b01; req = 1'b1; req_addr = mk_addr(21'h500, 6'd3, 3'd0);
        @(negedge clk);
        req = 1'b0;
        check("R8 miss on change cycle", 64'(rsp_hit), 64'd0);
        look("R8 flushed after change", mk_addr(21'h600, 6'd3, 3'd0), 1'b0, 2'd0, 24'h0);
    endtask

    task automatic t_two_way;
        // R5: pointer at 2
        refill(mk_addr(21'h101, 6'd7, 3'd0), 24'h61);
        look("R5 bit11=1 to way2", mk_addr(21'h101, 6'd7, 3'd4), 1'b1, 2'd2, 24'h61);
        look("R5 bit12 is in tag", mk_addr(21'h103, 6'd7, 3'd0), 1'b0, 2'd0, 24'h0);
        refill(mk_addr(21'h110, 6'd7, 3'd0), 24'h62);
        refill(mk_addr(21'h120, 6'd7, 3'd0), 24'h63);
        look("R5 R9 bit11=0 wrap to way0", mk_addr(21'h110, 6'd7, 3'd6), 1'b1, 2'd0, 24'h62);
        look("R5 second pair line way1", mk_addr(21'h120, 6'd7, 3'd1), 1'b1, 2'd1, 24'h63);
        look("R5 pair 2/3 kept", mk_addr(21'h101, 6'd7, 3'd0), 1'b1, 2'd2, 24'h61);
    endtask

    task automatic t_direct;
        // R6: bits 12..11 = 11 -> way3
        setcfg(2'b10, 4'hF);
        look("R8 flushed by DM switch", mk_addr(21'h101, 6'd7, 3'd0), 1'b0, 2'd0, 24'h0);
        refill(mk_addr(21'h0A3, 6'd9, 3'd0), 24'h71);
        look("R6 J in way3", mk_addr(21'h0A3, 6'd9, 3'd2), 1'b1, 2'd3, 24'h71);
        refill(mk_addr(21'h0B3, 6'd9, 3'd0), 24'h72);
        look("R6 K replaced J", mk_addr(21'h0B3, 6'd9, 3'd0), 1'b1, 2'd3, 24'h72);
        look("R6 J gone", mk_addr(21'h0A3, 6'd9, 3'd0), 1'b0, 2'd0, 24'h0);
    endtask

    task automatic t_way_enable;
        // R7: four-way with ways 0 and 2 only, pointer at 0
        setcfg(2'b00, 4'b0101);
        refill(mk_addr(21'h111, 6'd12, 3'd0), 24'h81);
        refill(mk_addr(21'h222, 6'd12, 3'd0), 24'h82);
        refill(mk_addr(21'h333, 6'd12, 3'd0), 24'h83);
        look("R7 M in way2", mk_addr(21'h222, 6'd12, 3'd3), 1'b1, 2'd2, 24'h82);
        look("R7 N in way0 skipping way3", mk_addr(21'h333, 6'd12, 3'd0), 1'b1, 2'd0, 24'h83);
        look("R7 L evicted", mk_addr(21'h111, 6'd12, 3'd0), 1'b0, 2'd0, 24'h0);
        setcfg(2'b10, 4'b0101);
        refill(mk_addr(21'h001, 6'd12, 3'd0), 24'h91);
        look("R7 refill to dead way dropped", mk_addr(21'h001, 6'd12, 3'd0), 1'b0, 2'd0, 24'h0);
        refill(mk_addr(21'h004, 6'd12, 3'd0), 24'h92);
        look("R7 live DM way0", mk_addr(21'h004, 6'd12, 3'd5), 1'b1, 2'd0, 24'h92);
        setcfg(2'b10, 4'b1101);
        look("R8 enable change flushes", mk_addr(21'h004, 6'd12, 3'd5), 1'b0, 2'd0, 24'h0);
        // R8: refill in the change cycle is dropped
        @(negedge clk);
        way_en = 4'b1111; refill_we = 1'b1;
        refill_addr = mk_addr(21'h008, 6'd13, 3'd0); refill_line = mk_line(24'h93);
        @(negedge clk);
        refill_we = 1'b0;
        look("R8 refill on change dropped", mk_addr(21'h008, 6'd13, 3'd0), 1'b0, 2'd0, 24'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_mode = 2'b00; way_en = 4'hF; req = 1'b0; req_addr = '0;
        refill_we = 1'b0; refill_addr = '0; refill_line = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_four_way();
        t_rewrite();
        t_flush();
        t_two_way();
        t_direct();
        t_way_enable();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule